// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block serves one bank of up to 32 general-purpose pins. Each pin has its own control word on a single-cycle register port. That word chooses whether the pin drives its pad or only listens. It also selects a pull resistor and its direction, and it sets how the pin raises an interrupt. Pad inputs are brought into the clock domain before any detection. The synchronized value can be read back from the pin's control word.

Three mode bits (high, low, type) select the detector. An edge detector compares the synchronized pad value with its value one cycle earlier. A level detector looks at the synchronized value alone. A hit sets a sticky status bit in the pin's word. Software acknowledges it by writing back the word it has just read, because the status bit clears on a write of one. A second read-only word gathers every pin's status bit. The single line to the parent controller is the registered OR of the pending pins whose interrupt enable is set.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset every register is zero: all pins are undriven inputs with no pull, interrupts are off, `irq` is low and every control word reads zero apart from its pad bit.
- R2: Pin n's control word is at word address n (0 to 31). The bank status word is at address 32. Any other address reads zero and ignores writes. Control word layout: bit 0 pad value, bit 1 output value, bit 2 output enable, bit 3 high, bit 4 low, bit 5 type, bit 6 interrupt enable, bit 7 status, bit 8 pull enable, bit 9 pull up. All other bits read zero.
- R3: A write to a control word updates `pad_out` (bit 1) and `pad_oe` (bit 2) of that pin at the next clock edge. With bit 2 clear the pin is an input. Without a write these outputs hold.
- R4: Bit 0 returns the pad input after a two-flop synchronizer, so it shows a pad change two clock edges later. Writes to bit 0 have no effect.
- R5: Bit 8 drives `pad_pull_en`. Bit 9 drives `pad_pull_up`: 1 selects pull-up and 0 selects pull-down.
- R6: With type=1, high=1 and low=0 a rising edge sets the status. With low=1 and high=0 a falling edge sets it. With high=1 and low=1 either edge sets it. The status is visible on the third clock edge after the pad change.
- R7: With type=0, high=1 and low=0 a high level sets the status. With low=1 and high=0 a low level sets it. While the level is still present, a clear written in the same cycle loses, so the status stays set.
- R8: Status is sticky. Writing 1 to bit 7 clears it and writing 0 leaves it, so writing back the word just read acknowledges the interrupt.
- R9: Bit n of the bank status word is pin n's status, whether or not its enable is set. Writes to that word have no effect.
- R10: `irq` is registered. It is high one cycle after any pin has both status and interrupt enable set. A pending pin whose enable is clear does not raise it.
- R11: With type=0 and high equal to low, no pad activity sets the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Word address of the register port |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad input values |
| pad_out | output | 32 | Value driven on each pad |
| pad_oe | output | 32 | Per-pad output enable |
| pad_pull_en | output | 32 | Per-pad pull resistor enable |
| pad_pull_up | output | 32 | Per-pad pull direction, 1 = up |
| irq | output | 1 | Registered bank interrupt to the parent |

## Verification
The edge properties are written on the synchronized pad value. They assume each pad level lasts at least one clock after synchronization, because a shorter glitch may never reach the detector. They also assume at most one register write per cycle, so at most one pin's write strobe is active at a time. The stimulus changes pads only at falling clock edges and holds each value for at least four cycles. It drives one write per access and lets a pin's pad settle before arming an edge mode, so no stale edge is caught.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int CTRL_W = 10;   // implemented bits of a pin control word
    localparam int BIT_STS = 7;   // write-one-to-clear status position

    // Control word bits 9..1, MSB first; bit 0 is the pad value.
    typedef struct packed {
        logic pull_up;
        logic pull_en;
        logic sts;
        logic ie;
        logic ty;
        logic lo;
        logic hi;
        logic oe;
        logic dout;
    } pin_cfg_t;

    typedef enum logic [2:0] {
        DET_NONE,
        DET_RISE,
        DET_FALL,
        DET_BOTH,
        DET_LVL_HI,
        DET_LVL_LO
    } det_mode_t;

    function automatic det_mode_t decode_mode(logic hi, logic lo, logic ty);
        det_mode_t m;
        if (ty) begin
            if (hi && lo)      m = DET_BOTH;
            else if (hi)       m = DET_RISE;
            else if (lo)       m = DET_FALL;
            else               m = DET_NONE;
        end else begin
            if (hi && !lo)     m = DET_LVL_HI;
            else if (lo && !hi) m = DET_LVL_LO;
            else               m = DET_NONE;
        end
        return m;
    endfunction

    function automatic logic detect(det_mode_t m, logic cur, logic prv);
        logic hit;
        case (m)
            DET_RISE:   hit = cur && !prv;
            DET_FALL:   hit = !cur && prv;
            DET_BOTH:   hit = cur ^ prv;
            DET_LVL_HI: hit = cur;
            DET_LVL_LO: hit = !cur;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpb_pin.sv
module gpb_pin
    import gpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              pad_s,
    output pin_cfg_t          cfg_o,
    output logic [CTRL_W-1:0] rd_o
);
    pin_cfg_t  cfg_q;
    pin_cfg_t  wr_cfg;
    logic      prev_q;
    logic      hit;
    logic      clr_req;
    det_mode_t mode;

    assign wr_cfg  = pin_cfg_t'(wdata[CTRL_W-1:1]);
    assign clr_req = wr_en && wdata[BIT_STS];
    assign mode    = decode_mode(cfg_q.hi, cfg_q.lo, cfg_q.ty);
    assign hit     = detect(mode, pad_s, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= pad_s;
            if (wr_en) begin
                cfg_q.dout    <= wr_cfg.dout;
                cfg_q.oe      <= wr_cfg.oe;
                cfg_q.hi      <= wr_cfg.hi;
                cfg_q.lo      <= wr_cfg.lo;
                cfg_q.ty      <= wr_cfg.ty;
                cfg_q.ie      <= wr_cfg.ie;
                cfg_q.pull_en <= wr_cfg.pull_en;
                cfg_q.pull_up <= wr_cfg.pull_up;
            end
            // a detection in the same cycle outranks the clear
            if (hit)          cfg_q.sts <= 1'b1;
            else if (clr_req) cfg_q.sts <= 1'b0;
        end
    end

    assign cfg_o = cfg_q;
    assign rd_o  = {cfg_q, pad_s};

    // R8: a clear without a competing hit empties the status
    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !hit) |=> !cfg_q.sts);

    // R8: status holds until cleared
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.sts && !clr_req) |=> cfg_q.sts);

    // R6: rising edge in rising-only mode is captured
    assert_rise_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.ty && cfg_q.hi && !cfg_q.lo && pad_s && !prev_q) |=> cfg_q.sts);

    // R11: idle mode never raises status
    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.sts && !cfg_q.ty && (cfg_q.hi == cfg_q.lo)) |=> !cfg_q.sts);

    // R3: settings other than status only move on a write
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable({cfg_q.pull_up, cfg_q.pull_en, cfg_q.ie, cfg_q.ty,
                            cfg_q.lo, cfg_q.hi, cfg_q.oe, cfg_q.dout}));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpb_pkg::*;
#(
    parameter int NUM_PINS   = 32,   // at most 32
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int STS_OFFSET = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pull_en,
    output logic [NUM_PINS-1:0] pad_pull_up,
    output logic                irq
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [ADDR_W-1:0] PIN_LIMIT = ADDR_W'(NUM_PINS);
    localparam logic [ADDR_W-1:0] STS_ADDR  = ADDR_W'(STS_OFFSET);

    logic [NUM_PINS-1:0] pad_s;
    logic [NUM_PINS-1:0] wr_sel;
    logic [NUM_PINS-1:0] sts_vec;
    logic [NUM_PINS-1:0] ie_vec;
    logic [CTRL_W-1:0]   pin_rd [NUM_PINS];
    logic                irq_q;

    gpb_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pad_s)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_cfg_t cfg;

        assign wr_sel[i] = bus_we && (bus_addr == ADDR_W'(i));

        gpb_pin u_pin (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_sel[i]),
            .wdata (bus_wdata[CTRL_W-1:0]),
            .pad_s (pad_s[i]),
            .cfg_o (cfg),
            .rd_o  (pin_rd[i])
        );

        assign pad_out[i]     = cfg.dout;
        assign pad_oe[i]      = cfg.oe;
        assign pad_pull_en[i] = cfg.pull_en;
        assign pad_pull_up[i] = cfg.pull_up;
        assign sts_vec[i]     = cfg.sts;
        assign ie_vec[i]      = cfg.ie;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < PIN_LIMIT)
            bus_rdata = DATA_W'(pin_rd[bus_addr[IDX_W-1:0]]);
        else if (bus_addr == STS_ADDR)
            bus_rdata = DATA_W'(sts_vec);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(sts_vec & ie_vec);
    end

    assign irq = irq_q;

    // R2: one write reaches at most one pin
    assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

    // R10: the line only rises when some pin was enabled the cycle before
    assert_irq_enable_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|ie_vec));
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic        irq;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    gpio_irq_bank dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .irq(irq)
    );

    // {high, low, type, pad before, pad after, expected status}
    localparam logic [5:0] VEC [13] = '{
        6'b101_01_1, 6'b101_10_0, 6'b011_10_1, 6'b011_01_0,
        6'b111_01_1, 6'b111_10_1, 6'b111_00_0, 6'b100_00_0,
        6'b100_01_1, 6'b010_11_0, 6'b010_10_1, 6'b000_01_0,
        6'b110_01_0
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = 6'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        bus_addr = 6'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(0, r);  check("R1 ctrl0", r, 32'h0);
        rd(32, r); check("R1 status", r, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 oe", pad_oe, 32'h0);

        // R6 / R7 / R11 mode table
        for (int i = 0; i < 13; i++) begin
            logic [5:0] v;
            logic [31:0] mw;
            string tag;
            v   = VEC[i];
            tag = v[3] ? "R6 mode" : ((v[5] ^ v[4]) ? "R7 mode" : "R11 mode");
            mw  = (32'(v[5]) << 3) | (32'(v[4]) << 4) | (32'(v[3]) << 5);
            wr(i, 32'h0);
            pad_in[i] = v[2];
            repeat (4) @(negedge clk);
            wr(i, mw | 32'h80);
            pad_in[i] = v[1];
            repeat (4) @(negedge clk);
            rd(i, r);
            check(tag, 32'(r[7]), 32'(v[0]));
            wr(i, 32'h0);
            wr(i, 32'h80);
        end

        // R3 output drive
        wr(20, 32'h6);
        check("R3 oe", 32'(pad_oe[20]), 32'h1);
        check("R3 out", 32'(pad_out[20]), 32'h1);

        // R5 pull control
        wr(21, 32'h300);
        check("R5 pull up", {30'b0, pad_pull_en[21], pad_pull_up[21]}, 32'h3);
        wr(21, 32'h100);
        check("R5 pull down", {30'b0, pad_pull_en[21], pad_pull_up[21]}, 32'h2);

        // R4 pad value: write ignored, two-edge latency
        wr(22, 32'h1);
        rd(22, r); check("R4 write ignored", r, 32'h0);
        pad_in[22] = 1'b1;
        @(negedge clk);
        rd(22, r); check("R4 one edge", r, 32'h0);
        @(negedge clk);
        rd(22, r); check("R4 two edges", r, 32'h1);

        // R9 / R10 / R8 / R2 enable gating and acknowledge
        wr(24, 32'h28);
        pad_in[24] = 1'b1;
        repeat (4) @(negedge clk);
        rd(32, r); check("R9 status bit", r, 32'h0100_0000);
        check("R10 disabled", 32'(irq), 32'h0);
        wr(24, 32'h68);
        check("R10 registered", 32'(irq), 32'h0);
        @(negedge clk);
        check("R10 enabled", 32'(irq), 32'h1);
        rd(24, r); check("R2 layout", r, 32'hE9);
        wr(24, r);
        check("R10 lag", 32'(irq), 32'h1);
        rd(24, r); check("R8 ack", 32'(r[7]), 32'h0);
        @(negedge clk);
        check("R10 fall", 32'(irq), 32'h0);

        // R7 level held beats clear
        pad_in[25] = 1'b1;
        repeat (4) @(negedge clk);
        wr(25, 32'h48);
        @(negedge clk);
        rd(25, r); check("R7 level set", 32'(r[7]), 32'h1);
        wr(25, 32'hC8);
        rd(25, r); check("R7 clear loses", 32'(r[7]), 32'h1);
        pad_in[25] = 1'b0;
        repeat (4) @(negedge clk);
        wr(25, 32'hC8);
        rd(25, r); check("R8 clear level gone", 32'(r[7]), 32'h0);
        wr(25, 32'h0);

        // R9 writes to the status word ignored; R2 unmapped address
        wr(32, 32'hFFFF_FFFF);
        rd(32, r);  check("R9 write ignored", r, 32'h0);
        rd(20, r);  check("R9 no side effect", r, 32'h6);
        wr(40, 32'h3FF);
        rd(40, r);  check("R2 unmapped", r, 32'h0);

        finish_run();
    end
endmodule